// File: doc/BRIEF.md
# Pipelined 64-bit Ethernet CRC-32 Generator

This block computes the Ethernet frame check sequence over a stream of 64-bit words, eight bytes per clock. Each word is qualified by a valid input. An end-of-packet input marks the last word of a frame. On that word a 3-bit mask gives the number of unused upper lanes. The block keeps a running CRC register that returns to its seed after every frame. Consecutive frames therefore need no idle cycle between them.

For the final word, the block forms one candidate remainder for each possible byte count, all in parallel. A later stage picks one candidate using the delayed mask. It then complements the result and orders its bytes, so the output equals the received FCS when that FCS is packed with its first-received byte in the top bits. A receiver decides whether a frame is good with a single 32-bit equality compare. The result and a one-cycle strobe appear a fixed number of clocks after the final word.

Top module: `eth_crc64_pipe`

## Requirements
- R1: While reset is high, and for the first cycle after it is released, `crc_vld` is low. Reset discards any partly received frame: a frame sent after reset gives the CRC of that frame alone.
- R2: A cycle with `din_vld` low leaves the result unchanged, whatever is on `din_data`. Idle cycles inside a frame do not alter its CRC.
- R3: Frames whose length is a multiple of eight bytes give the CRC over all bytes of every word.
- R4: On the final word, `din_mask` = m marks the upper m lanes as unused. The value 000 means all eight bytes are valid, 001 means seven, and 111 means only byte 0. Bytes in unused lanes never affect the result.
- R5: Within a word, byte 0 sits in bits 7:0 and is the earliest byte on the wire. Byte k sits in bits 8k+7:8k.
- R6: Suppose the final word is accepted on a rising edge. `crc_vld` and `crc_out` then become valid right after the fourth rising edge, counting that accepting edge as the first. They hold for exactly one cycle for that frame.
- R7: Each accepted end-of-packet word produces exactly one `crc_vld` pulse, and no pulse occurs without one.
- R8: The CRC uses the reflected form of polynomial 0x04C11DB7, a seed of all ones and a final complement. `crc_out[31:24]` holds the first FCS byte on the wire, and `crc_out[7:0]` holds the last. The nine ASCII bytes "123456789" give 0x2639F4CB.
- R9: The running CRC reloads its seed after every end-of-packet word. A frame that starts on the cycle right after the previous frame's last word, or one idle cycle later, is computed correctly.
- R10: `din_mask` has no effect on words that do not carry end-of-packet.
- R11: `din_eop` has no effect while `din_vld` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data clock |
| rst | input | 1 | Synchronous reset, active high |
| din_data | input | 64 | Frame bytes, byte 0 in bits 7:0 |
| din_vld | input | 1 | Word qualifier |
| din_eop | input | 1 | Final word of a frame |
| din_mask | input | 3 | Count of unused upper lanes on the final word |
| crc_out | output | 32 | FCS in wire order, first byte in bits 31:24 |
| crc_vld | output | 1 | One-cycle strobe marking `crc_out` |

## Verification
Two functions can fall in the same clock. One is the reload of the running register for a new frame. The other is the capture of the previous frame's final candidates, and the result of that earlier frame is still travelling through the output stages at the same moment. The bench provokes this overlap with runs of single-word frames sent with no gap and with one-cycle gaps. A scoreboard then judges each pulse: it must carry the value of a bytewise reference model and arrive on the exact predicted cycle, and no pulse may be missing or extra.

// File: rtl/eth_crc64_pkg.sv
package eth_crc64_pkg;

   localparam int CRC_W = 32;

   typedef logic [CRC_W-1:0] crc_t;

   // Bit reversal of a 32-bit word (normal polynomial -> reflected form)
   function automatic crc_t crc_bit_rev(input crc_t v);
      crc_t r;
      for (int i = 0; i < CRC_W; i++) begin
         r[i] = v[CRC_W-1-i];
      end
      return r;
   endfunction

   // One byte through a reflected LFSR, least significant bit first
   function automatic crc_t crc_step_byte(input crc_t c, input logic [7:0] d,
                                          input crc_t rpoly);
      crc_t r;
      r = c ^ {{(CRC_W-8){1'b0}}, d};
      for (int i = 0; i < 8; i++) begin
         r = r[0] ? ((r >> 1) ^ rpoly) : (r >> 1);
      end
      return r;
   endfunction

   // Complement, then put the first transmitted FCS byte on top
   function automatic crc_t crc_wire_order(input crc_t c);
      crc_t f;
      crc_t r;
      f = ~c;
      for (int i = 0; i < CRC_W/8; i++) begin
         r[8*(CRC_W/8-1-i) +: 8] = f[8*i +: 8];
      end
      return r;
   endfunction

endpackage

// File: rtl/crc64_fold.sv
module crc64_fold
   import eth_crc64_pkg::*;
#(
   parameter int   DATA_W = 64,
   parameter crc_t POLY   = 32'h04C11DB7,
   parameter crc_t SEED   = 32'hFFFFFFFF,
   localparam int  NBYTES = DATA_W / 8,
   localparam int  MASK_W = $clog2(NBYTES)
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          w_vld,
   input  logic                          w_eop,
   input  logic [MASK_W-1:0]             w_mask,
   input  logic [DATA_W-1:0]             w_data,
   output logic                          cand_vld,
   output logic [MASK_W-1:0]             cand_mask,
   output logic [NBYTES-1:0][CRC_W-1:0]  cand
);

   localparam crc_t RPOLY = crc_bit_rev(POLY);

   crc_t                       run_crc;
   logic [NBYTES-1:0][CRC_W-1:0] chain;

   // chain[k] is the remainder after bytes 0..k of the current word
   always_comb begin
      crc_t acc;
      acc = run_crc;
      for (int b = 0; b < NBYTES; b++) begin
         acc      = crc_step_byte(acc, w_data[8*b +: 8], RPOLY);
         chain[b] = acc;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         run_crc  <= SEED;
         cand_vld <= 1'b0;
      end else begin
         cand_vld <= w_vld & w_eop;
         if (w_vld) begin
            run_crc <= w_eop ? SEED : chain[NBYTES-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (w_vld & w_eop) begin
         cand      <= chain;
         cand_mask <= w_mask;
      end
   end

   // R2: no valid word, no change of the running remainder
   a_r2_hold_when_idle : assert property (@(posedge clk) disable iff (rst)
      !w_vld |=> $stable(run_crc));

   // R9: the seed is back in place right after a final word
   a_r9_reseed_after_eop : assert property (@(posedge clk) disable iff (rst)
      (w_vld && w_eop) |=> (run_crc == SEED));

endmodule

// File: rtl/crc64_pick.sv
module crc64_pick
   import eth_crc64_pkg::*;
#(
   parameter int  NBYTES = 8,
   localparam int MASK_W = $clog2(NBYTES)
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          cand_vld,
   input  logic [MASK_W-1:0]             cand_mask,
   input  logic [NBYTES-1:0][CRC_W-1:0]  cand,
   output logic                          fcs_vld,
   output crc_t                          fcs
);

   // m unused upper lanes -> NBYTES-m valid bytes -> candidate index NBYTES-1-m
   logic [MASK_W-1:0] sel;
   assign sel = MASK_W'(NBYTES-1) - cand_mask;

   always_ff @(posedge clk) begin
      if (rst) begin
         fcs_vld <= 1'b0;
      end else begin
         fcs_vld <= cand_vld;
      end
   end

   always_ff @(posedge clk) begin
      if (cand_vld) begin
         fcs <= crc_wire_order(cand[sel]);
      end
   end

endmodule

// File: rtl/crc64_delay.sv
module crc64_delay #(
   parameter int DEPTH = 1,
   parameter int W     = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_vld,
   input  logic [W-1:0] in_val,
   output logic         out_vld,
   output logic [W-1:0] out_val
);

   generate
      if (DEPTH == 0) begin : g_pass
         assign out_vld = in_vld;
         assign out_val = in_val;
      end else begin : g_regs
         logic [DEPTH-1:0]        v_q;
         logic [DEPTH-1:0][W-1:0] d_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               v_q <= '0;
            end else begin
               v_q[0] <= in_vld;
               for (int i = 1; i < DEPTH; i++) begin
                  v_q[i] <= v_q[i-1];
               end
            end
         end

         always_ff @(posedge clk) begin
            d_q[0] <= in_val;
            for (int i = 1; i < DEPTH; i++) begin
               d_q[i] <= d_q[i-1];
            end
         end

         assign out_vld = v_q[DEPTH-1];
         assign out_val = d_q[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/eth_crc64_pipe.sv
module eth_crc64_pipe
   import eth_crc64_pkg::*;
#(
   parameter int   DATA_W  = 64,
   parameter int   LATENCY = 4,
   parameter crc_t POLY    = 32'h04C11DB7,
   parameter crc_t SEED    = 32'hFFFFFFFF,
   localparam int  NBYTES  = DATA_W / 8,
   localparam int  MASK_W  = $clog2(NBYTES),
   localparam int  XTRA    = LATENCY - 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] din_data,
   input  logic              din_vld,
   input  logic              din_eop,
   input  logic [MASK_W-1:0] din_mask,
   output logic [31:0]       crc_out,
   output logic              crc_vld
);

   // Elaboration-time parameter checks
   generate
      if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_width
         $error("DATA_W must be a multiple of 8 and at least 16");
      end
      if ((NBYTES & (NBYTES - 1)) != 0) begin : g_bad_lanes
         $error("DATA_W/8 must be a power of two");
      end
      if (LATENCY < 3) begin : g_bad_latency
         $error("LATENCY must be at least 3");
      end
   endgenerate

   // Stage 1: input capture
   logic              in_vld;
   logic              in_eop;
   logic [MASK_W-1:0] in_mask;
   logic [DATA_W-1:0] in_data;

   always_ff @(posedge clk) begin
      if (rst) begin
         in_vld <= 1'b0;
         in_eop <= 1'b0;
      end else begin
         in_vld <= din_vld;
         in_eop <= din_vld & din_eop;
      end
   end

   always_ff @(posedge clk) begin
      in_data <= din_data;
      in_mask <= din_mask;
   end

   // Stage 2: running remainder and per-length candidates
   logic                         cand_vld;
   logic [MASK_W-1:0]            cand_mask;
   logic [NBYTES-1:0][CRC_W-1:0] cand;

   crc64_fold #(
      .DATA_W (DATA_W),
      .POLY   (POLY),
      .SEED   (SEED)
   ) i_fold (
      .clk       (clk),
      .rst       (rst),
      .w_vld     (in_vld),
      .w_eop     (in_eop),
      .w_mask    (in_mask),
      .w_data    (in_data),
      .cand_vld  (cand_vld),
      .cand_mask (cand_mask),
      .cand      (cand)
   );

   // Stage 3: lane-count select and wire-order finish
   logic fcs_vld;
   crc_t fcs;

   crc64_pick #(
      .NBYTES (NBYTES)
   ) i_pick (
      .clk       (clk),
      .rst       (rst),
      .cand_vld  (cand_vld),
      .cand_mask (cand_mask),
      .cand      (cand),
      .fcs_vld   (fcs_vld),
      .fcs       (fcs)
   );

   // Remaining stages up to the configured latency
   crc64_delay #(
      .DEPTH (XTRA),
      .W     (CRC_W)
   ) i_delay (
      .clk     (clk),
      .rst     (rst),
      .in_vld  (fcs_vld),
      .in_val  (fcs),
      .out_vld (crc_vld),
      .out_val (crc_out)
   );

   // Checker history of accepted final words, kept apart from the datapath
   logic [LATENCY-1:0] chk_hist;

   always_ff @(posedge clk) begin
      if (rst) begin
         chk_hist <= '0;
      end else begin
         chk_hist <= {chk_hist[LATENCY-2:0], din_vld & din_eop};
      end
   end

   // R6 / R7: a strobe exactly LATENCY edges after each accepted final word
   a_r6_fixed_latency : assert property (@(posedge clk) disable iff (rst)
      crc_vld == chk_hist[LATENCY-1]);

   // R1: nothing pending on the first cycle out of reset
   a_r1_quiet_after_reset : assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> !crc_vld);

endmodule

// File: tb/test_eth_crc64_pipe.sv
module test_eth_crc64_pipe;

   localparam int WATCHDOG = 100000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [63:0] din_data = '0;
   logic        din_vld = 1'b0;
   logic        din_eop = 1'b0;
   logic [2:0]  din_mask = '0;
   logic [31:0] crc_out;
   logic        crc_vld;

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   int frames = 0;
   int pulses = 0;

   typedef struct {
      int          due;
      logic [31:0] val;
      string       tag;
   } exp_t;

   exp_t sb[$];

   eth_crc64_pipe i_eth_crc64_pipe (
      .clk      (clk),
      .rst      (rst),
      .din_data (din_data),
      .din_vld  (din_vld),
      .din_eop  (din_eop),
      .din_mask (din_mask),
      .crc_out  (crc_out),
      .crc_vld  (crc_vld)
   );

   always #4 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   // Reference: bit-serial reflected CRC, complemented, first FCS byte on top (R8)
   function automatic logic [31:0] ref_fcs(input logic [7:0] fr[$]);
      logic [31:0] c;
      logic [31:0] f;
      logic        fb;
      c = 32'hFFFFFFFF;
      foreach (fr[i]) begin
         for (int k = 0; k < 8; k++) begin
            fb = c[0] ^ fr[i][k];
            c  = {1'b0, c[31:1]};
            if (fb) c = c ^ 32'hEDB88320;
         end
      end
      f = ~c;
      return {f[7:0], f[15:8], f[23:16], f[31:24]};
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (!rst && crc_vld) begin
         pulses++;
         if (sb.size() == 0) begin
            check(1'b0, "R7 unexpected pulse", crc_out, 32'h0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(crc_out == e.val, e.tag, crc_out, e.val);
            check(cyc == e.due, "R6 latency", 32'(cyc), 32'(e.due));
         end
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         din_vld  = 1'b0;
         din_eop  = i[0];              // R11: end flag without valid
         din_data = {8{8'(i * 29 + 3)}};
         din_mask = 3'(i + 5);
      end
   endtask

   task automatic send_bytes(input logic [7:0] fr[$], input int gap_every,
                             input int idle_after, input string tag);
      int nw;
      int rem;
      nw = (fr.size() + 7) / 8;
      for (int w = 0; w < nw; w++) begin
         if (gap_every > 0 && w > 0 && (w % gap_every) == 0) idle(1);  // R2
         @(negedge clk);
         din_vld = 1'b1;
         din_eop = (w == nw - 1);
         for (int b = 0; b < 8; b++) begin
            din_data[8*b +: 8] = (w*8 + b < fr.size()) ? fr[w*8 + b] : 8'(8'hA5 ^ b);
         end
         rem = fr.size() - w*8;
         din_mask = (w == nw - 1) ? 3'(8 - rem) : 3'(w + 3);   // R4 / R10
         if (w == nw - 1) begin
            exp_t e;
            e.due = cyc + 4;
            e.val = ref_fcs(fr);
            e.tag = tag;
            sb.push_back(e);
            frames++;
         end
      end
      idle(idle_after);
   endtask

   task automatic send_frame(input int len, input int seed, input int gap_every,
                             input int idle_after, input string tag);
      logic [7:0] fr[$];
      for (int i = 0; i < len; i++) fr.push_back(8'(i * 37 + seed * 13 + 1));
      send_bytes(fr, gap_every, idle_after, tag);
   endtask

   // Watchdog
   always @(posedge clk) begin
      if (cyc >= WATCHDOG) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] kv[$];

      // R1: quiet in and right after reset
      repeat (4) begin
         @(negedge clk);
         check(crc_vld == 1'b0, "R1 in reset", {31'b0, crc_vld}, 32'h0);
      end
      rst = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(crc_vld == 1'b0, "R1 after reset", {31'b0, crc_vld}, 32'h0);
      end

      // R8: reference model against the standard check string
      kv = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
      check(ref_fcs(kv) == 32'h2639F4CB, "R8 model", ref_fcs(kv), 32'h2639F4CB);
      // R8 / R5 / R4: nine bytes, final word with mask 111
      send_bytes(kv, 0, 3, "R8 check string");

      // R3 / R4: every residue modulo 8, one to four words
      for (int len = 1; len <= 32; len++) begin
         send_frame(len, len, 0, 2, (len % 8 == 0) ? "R3 full words" : "R4 partial word");
      end

      // R2 / R10 / R11: idle gaps inside frames, garbage mask and end flag
      for (int len = 17; len <= 40; len += 3) begin
         send_frame(len, len + 7, 1, 1, "R2 gaps inside frame");
      end

      // R9: back to back with one idle cycle, then with none
      for (int len = 60; len <= 67; len++) send_frame(len, len, 0, 1, "R9 one idle");
      for (int len = 1; len <= 16; len++) send_frame(len, len * 3, 0, 0, "R9 no idle");
      // R7: single-word frames every cycle
      for (int len = 1; len <= 8; len++) send_frame(len, 50 + len, 0, 0, "R7 single word");
      idle(8);

      // R1: reset in the middle of a frame discards it
      @(negedge clk);
      din_vld  = 1'b1;
      din_eop  = 1'b0;
      din_data = 64'h0123_4567_89AB_CDEF;
      @(negedge clk);
      din_vld = 1'b0;
      rst     = 1'b1;
      @(negedge clk);
      check(crc_vld == 1'b0, "R1 mid-frame reset", {31'b0, crc_vld}, 32'h0);
      rst = 1'b0;
      send_frame(13, 99, 0, 2, "R1 frame after reset");
      send_frame(64, 5, 2, 10, "R3 long frame");

      check(sb.size() == 0, "R7 missing pulses", 32'(sb.size()), 32'h0);
      check(pulses == frames, "R7 pulse count", 32'(pulses), 32'(frames));

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule